// File: doc/BRIEF.md
# Credit-Based Transmit Gate

This block sits on the transmit side of a point-to-point link and decides, cycle by cycle, whether the packet at the head of the outbound queue may leave. The far-end receiver advertises how much buffer space it has. The gate keeps two wrapping counters:

- a credit limit, loaded with that advertisement and raised whenever the receiver hands credits back;
- a consumed-credit total, raised by the cost of every packet released.

A packet is released only when sending it keeps consumption inside the limit. That test is done by modular subtraction, so both counters can wrap freely.

The queue presents its head packet with a valid flag and a credit cost, and it holds them until the grant output is seen high. The grant is computed combinationally from the registered counters. While credit remains, a packet leaves in the same cycle it is presented, however slowly credit returns arrive. A packet that does not fit stays at the head, and nothing behind it is reordered around it.

Top module: `credit_gate`

## Requirements
- R1: After reset, `pkt_grant` stays low for every request until an initial credit load (`init_valid` high for one cycle) has been taken.
- R2: A load sets the credit limit to `init_credits` and clears the consumed total to zero. From the next cycle, packets are judged against that new window. A load takes priority over a credit return in the same cycle.
- R3: With the gate loaded and `init_valid` low, `pkt_grant` equals `pkt_valid` AND (`(limit - consumed - pkt_cost) mod 2^CNT_W < 2^(CNT_W-1)`). The test is whether the most significant bit of the CNT_W-bit difference is 0. It is evaluated in the same cycle the request is presented.
- R4: Every cycle with `pkt_grant` high adds `pkt_cost` to the consumed total, modulo 2^CNT_W.
- R5: Every cycle with `ret_valid` high on a loaded gate adds `ret_credits` to the credit limit, modulo 2^CNT_W.
- R6: When a grant and a credit return fall in the same cycle, both updates take effect. The grant decision in that cycle uses the limit as it stood before the return.
- R7: A request whose cost exceeds the remaining credit gets no grant and is held at the head. It is granted in the first cycle after enough credit has been returned.
- R8: Both counters wrap through zero without disturbing the decision, provided the outstanding window (limit minus consumed) stays below 2^(CNT_W-1).
- R9: A request with cost 0 is always granted on a loaded gate, even when no credit remains.
- R10: In a cycle with `init_valid` high, `pkt_grant` is low whatever the request.
- R11: Credit returns taken before the first load are ignored. They do not enlarge the window that the load sets up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_valid | input | 1 | Load the initial credit limit this cycle |
| init_credits | input | CNT_W | Initial credit amount advertised by the receiver |
| pkt_valid | input | 1 | Head packet is waiting to be sent |
| pkt_cost | input | COST_W | Credit cost of the head packet |
| pkt_grant | output | 1 | Head packet is released this cycle |
| ret_valid | input | 1 | Receiver returns credits this cycle |
| ret_credits | input | CNT_W | Number of credits returned |

## Verification
The bench builds the gate with its default widths: 8-bit counters and 6-bit packet costs. With these widths a few dozen cost-15 packets carry the consumed total several times through zero. The half-range boundary at 128 can also be reached directly, so a plain magnitude comparison in place of the modular test would grant or refuse wrongly. The 6-bit cost also allows requests larger than a small initial window, which exercises head-of-line blocking and release by a later return.

// File: rtl/credit_gate_pkg.sv
package credit_gate_pkg;

    typedef enum logic {
        GATE_UNARMED = 1'b0,
        GATE_ARMED   = 1'b1
    } gate_phase_e;

endpackage

// File: rtl/cg_slack_check.sv
module cg_slack_check #(
    parameter int CNT_W  = 8,
    parameter int COST_W = 6
) (
    input  logic [CNT_W-1:0]  limit_i,
    input  logic [CNT_W-1:0]  used_i,
    input  logic [COST_W-1:0] cost_i,
    output logic              fits_o
);
    localparam int SIGN_BIT = CNT_W - 1;

    logic [CNT_W-1:0] slack;

    always_comb begin
        slack  = limit_i - used_i - CNT_W'(cost_i);
        fits_o = ~slack[SIGN_BIT];
    end

endmodule

// File: rtl/cg_wrap_accum.sv
module cg_wrap_accum #(
    parameter int CNT_W = 8,
    parameter int ADD_W = 8
) (
    input  logic [CNT_W-1:0] cur_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             add_i,
    input  logic [ADD_W-1:0] add_val_i,
    output logic [CNT_W-1:0] next_o
);
    always_comb begin
        if (load_i) begin
            next_o = load_val_i;
        end else if (add_i) begin
            next_o = cur_i + CNT_W'(add_val_i);
        end else begin
            next_o = cur_i;
        end
    end

endmodule

// File: rtl/credit_gate.sv
module credit_gate
    import credit_gate_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int COST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_valid,
    input  logic [CNT_W-1:0]  init_credits,
    input  logic              pkt_valid,
    input  logic [COST_W-1:0] pkt_cost,
    output logic              pkt_grant,
    input  logic              ret_valid,
    input  logic [CNT_W-1:0]  ret_credits
);
    typedef struct packed {
        gate_phase_e      phase;
        logic [CNT_W-1:0] limit;
        logic [CNT_W-1:0] used;
    } gate_state_t;

    gate_state_t st_d, st_q;

    logic             armed;
    logic             fits;
    logic             ret_take;
    logic [CNT_W-1:0] limit_nx;
    logic [CNT_W-1:0] used_nx;

    assign armed    = (st_q.phase == GATE_ARMED);
    assign ret_take = armed & ret_valid;

    cg_slack_check #(.CNT_W(CNT_W), .COST_W(COST_W)) u_slack (
        .limit_i (st_q.limit),
        .used_i  (st_q.used),
        .cost_i  (pkt_cost),
        .fits_o  (fits)
    );

    // Grant decision always sees the limit before any same-cycle return.
    assign pkt_grant = armed & pkt_valid & ~init_valid & fits;

    cg_wrap_accum #(.CNT_W(CNT_W), .ADD_W(CNT_W)) u_limit (
        .cur_i      (st_q.limit),
        .load_i     (init_valid),
        .load_val_i (init_credits),
        .add_i      (ret_take),
        .add_val_i  (ret_credits),
        .next_o     (limit_nx)
    );

    cg_wrap_accum #(.CNT_W(CNT_W), .ADD_W(COST_W)) u_used (
        .cur_i      (st_q.used),
        .load_i     (init_valid),
        .load_val_i ('0),
        .add_i      (pkt_grant),
        .add_val_i  (pkt_cost),
        .next_o     (used_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.limit = limit_nx;
        st_d.used  = used_nx;
        if (init_valid) begin
            st_d.phase = GATE_ARMED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= GATE_UNARMED;
            st_q.limit <= '0;
            st_q.used  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/credit_gate_chk.sv
module credit_gate_chk #(
    parameter int CNT_W  = 8,
    parameter int COST_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              init_valid,
    input logic              pkt_valid,
    input logic [COST_W-1:0] pkt_cost,
    input logic              pkt_grant,
    input logic              ret_valid,
    input logic [CNT_W-1:0]  ret_credits,
    input logic [CNT_W-1:0]  limit_q,
    input logic [CNT_W-1:0]  used_q
);
    logic seen_init;
    logic started;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_init <= 1'b0;
            started   <= 1'b0;
        end else begin
            started <= 1'b1;
            if (init_valid) seen_init <= 1'b1;
        end
    end

    // R1: no release before the first load
    a_r1_no_grant_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_init |-> !pkt_grant);

    // R10: load cycle never releases
    a_r10_no_grant_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        init_valid |-> !pkt_grant);

    // R3: grant only answers a request
    a_r3_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_grant |-> pkt_valid);

    // R6: grant plus return both land
    a_r6_both_updates: assert property (@(posedge clk) disable iff (!rst_n)
        (started && pkt_grant && ret_valid && !init_valid) |=>
            (limit_q == $past(limit_q + ret_credits)) &&
            (used_q  == $past(used_q + CNT_W'(pkt_cost))));

    // R7: a blocked head stays blocked while no credit arrives
    a_r7_blocked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (started && pkt_valid && !pkt_grant && !ret_valid && !init_valid) |=>
            (!(pkt_valid && $stable(pkt_cost)) || !pkt_grant));

    // R4: no grant, no consumption
    a_r4_used_only_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !pkt_grant && !init_valid) |=> $stable(used_q));

endmodule

bind credit_gate credit_gate_chk #(.CNT_W(CNT_W), .COST_W(COST_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_valid  (init_valid),
    .pkt_valid   (pkt_valid),
    .pkt_cost    (pkt_cost),
    .pkt_grant   (pkt_grant),
    .ret_valid   (ret_valid),
    .ret_credits (ret_credits),
    .limit_q     (st_q.limit),
    .used_q      (st_q.used)
);

// File: tb/tb_credit_gate.sv
module tb_credit_gate;
    localparam int CNT_W  = 8;
    localparam int COST_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              init_valid = 1'b0;
    logic [CNT_W-1:0]  init_credits = '0;
    logic              pkt_valid = 1'b0;
    logic [COST_W-1:0] pkt_cost = '0;
    logic              pkt_grant;
    logic              ret_valid = 1'b0;
    logic [CNT_W-1:0]  ret_credits = '0;

    int n_checks = 0;
    int n_fail   = 0;

    // bench-side expectation, built from the requirements
    logic             m_armed = 1'b0;
    logic [CNT_W-1:0] m_limit = '0;
    logic [CNT_W-1:0] m_used  = '0;

    always #10 clk = ~clk;

    credit_gate #(.CNT_W(CNT_W), .COST_W(COST_W)) dut (
        .clk, .rst_n, .init_valid, .init_credits, .pkt_valid, .pkt_cost,
        .pkt_grant, .ret_valid, .ret_credits
    );

    task automatic check(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: pkt_grant=%0b expected %0b", tag, got, exp);
        end
    endtask

    // One cycle: drive after the falling edge, compare grant, advance model at the rising edge.
    task automatic cycle(input string tag, input logic pv, input int cost,
                         input logic rv, input int ret, input logic iv, input int ini);
        logic [CNT_W-1:0] slack;
        logic             exp_g;
        pkt_valid    = pv;
        pkt_cost     = COST_W'(cost);
        ret_valid    = rv;
        ret_credits  = CNT_W'(ret);
        init_valid   = iv;
        init_credits = CNT_W'(ini);
        #2;
        slack = m_limit - m_used - CNT_W'(cost);
        exp_g = m_armed && pv && !iv && !slack[CNT_W-1];
        check(tag, pkt_grant, exp_g);
        @(posedge clk);
        if (iv) begin
            m_armed = 1'b1;
            m_limit = CNT_W'(ini);
            m_used  = '0;
        end else begin
            if (exp_g) m_used = m_used + CNT_W'(cost);
            if (rv && m_armed) m_limit = m_limit + CNT_W'(ret);
        end
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        check("R1 reset", pkt_grant, 1'b0);
        cycle("R1 request before load", 1, 0, 0, 0, 0, 0);
        cycle("R11 return before load", 1, 1, 1, 50, 0, 0);
    endtask

    task automatic t_load_and_basic;
        cycle("R10 load cycle no grant", 1, 1, 1, 20, 1, 10);
        cycle("R11 early return ignored, cost 11 over 10", 1, 11, 0, 0, 0, 0);
        cycle("R3 cost 4 fits", 1, 4, 0, 0, 0, 0);
        cycle("R4 cost 6 uses rest", 1, 6, 0, 0, 0, 0);
        cycle("R9 zero cost on empty window", 1, 0, 0, 0, 0, 0);
        cycle("R3 no request no grant", 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_block_release;
        cycle("R7 cost 5 blocked", 1, 5, 0, 0, 0, 0);
        cycle("R7 still blocked", 1, 5, 0, 0, 0, 0);
        cycle("R6 return 5 same cycle, old limit", 1, 5, 1, 5, 0, 0);
        cycle("R5 released after return", 1, 5, 0, 0, 0, 0);
        cycle("R4 window empty again", 1, 1, 0, 0, 0, 0);
    endtask

    task automatic t_same_cycle;
        cycle("R2 reload 8", 0, 0, 0, 0, 1, 8);
        cycle("R6 grant 8 with return 3", 1, 8, 1, 3, 0, 0);
        cycle("R6 both applied, 3 left", 1, 3, 0, 0, 0, 0);
        cycle("R6 nothing left", 1, 1, 0, 0, 0, 0);
    endtask

    task automatic t_wrap;
        cycle("R2 reload 100", 0, 0, 0, 0, 1, 100);
        for (int i = 0; i < 40; i++) begin
            cycle("R8 wrapping stream", 1, 15, 1, 15, 0, 0);
        end
        cycle("R8 full window after wrap", 1, 63, 0, 0, 0, 0);
        cycle("R8 remaining 37", 1, 38, 0, 0, 0, 0);
        cycle("R8 exact fit 37", 1, 37, 0, 0, 0, 0);
        cycle("R8 empty after wrap", 1, 1, 0, 0, 0, 0);
    endtask

    task automatic t_half_range;
        cycle("R2 reload 127", 0, 0, 0, 0, 1, 127);
        cycle("R3 cost 63", 1, 63, 0, 0, 0, 0);
        cycle("R3 cost 63", 1, 63, 0, 0, 0, 0);
        cycle("R3 one left, cost 2 refused", 1, 2, 0, 0, 0, 0);
        cycle("R3 one left, cost 1", 1, 1, 0, 0, 0, 0);
        cycle("R2 load beats return", 0, 0, 1, 40, 1, 2);
        cycle("R2 window 2 only, cost 3 refused", 1, 3, 0, 0, 0, 0);
        cycle("R2 window 2, cost 2", 1, 2, 0, 0, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        t_reset_state;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state;
        t_load_and_basic;
        t_block_release;
        t_same_cycle;
        t_wrap;
        t_half_range;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule